// File: doc/BRIEF.md
# Programmable-Frame Serial Transmitter

This block turns bytes into asynchronous serial frames on one output line. A frame is a low start bit, then 5 to 8 data bits sent least-significant bit first, then an optional parity bit, then a high stop period. The frame shape comes from plain line-control inputs. These set the character length, whether parity is used, its sense, and whether the stop period is long. Bit timing comes from a 16-bit divisor. The divisor counts pulses of a reference enable and so produces a tick at sixteen times the bit rate. That tick is also driven out as an active-low clock.

Bytes enter through a valid/ready write stream. `wr_ready` falls when the holding store is full. A byte is taken on any clock edge where `wr_valid` and `wr_ready` are both high. The producer must keep `wr_valid` and `wr_data` steady until that edge. The holding store is either a 16-entry queue or a single register, chosen by a mode input. Any change of that input discards every byte waiting. A break input forces the line low while it is held. Two status flags report whether bytes are waiting and whether the shifter has finished.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` = 1, `clk16_n` = 1, `hold_empty` = 1, `shift_empty` = 1 and `wr_ready` = 1.
- R2: A frame is one start bit of 0, followed by the data bits LSB first. The number of data bits is 5 + `char_len` (codes 0,1,2,3 give 5,6,7,8 bits). Every bit lasts exactly 16 ticks.
- R3: When `par_en` = 1, one parity bit follows the data. With `par_even` = 1 it makes the count of ones in data plus parity even; with `par_even` = 0 it makes that count odd. When `par_en` = 0, no parity bit is sent.
- R4: When `stop_long` = 0, the stop period lasts 16 ticks. When `stop_long` = 1, it lasts 32 ticks, or 24 ticks if `char_len` = 0.
- R5: The tick is a one-cycle pulse, issued once for every `divisor` cycles in which `ref_en` is high. `clk16_n` is low exactly in the tick cycles. With `divisor` = 0 there are no ticks and nothing is sent.
- R6: In queue mode (`fifo_en` = 1), up to 16 bytes are held. In single-register mode, one byte is held. `wr_ready` is low while the store is full.
- R7: Any change of `fifo_en` discards all waiting bytes.
- R8: `hold_empty` is high exactly when no byte is waiting.
- R9: `shift_empty` rises in the cycle after the tick that ends the last stop period. If a byte is waiting at that tick, its start bit begins at once with no idle tick between frames.
- R10: While `brk` = 1, `txd` = 0. The shifter keeps running and completes its frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | Reference clock enable counted by the divisor |
| divisor | input | 16 | Reference pulses per 16x tick; 0 stops ticks |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| char_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Send a parity bit |
| par_even | input | 1 | Parity sense: 1 even, 0 odd |
| stop_long | input | 1 | Long stop period (1.5 or 2 bits) |
| brk | input | 1 | Force line low |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| wr_data | input | 8 | Write stream byte |
| txd | output | 1 | Serial output, idles high |
| clk16_n | output | 1 | Active-low 16x tick |
| hold_empty | output | 1 | No byte waiting |
| shift_empty | output | 1 | Shifter idle |

## Verification
The hardest condition to reach is the handover from one frame to the next in the same tick. The stimulus must have a second byte already queued before the first frame's final stop tick. To get there, the bench queues two bytes back to back in queue mode before the first start bit has finished. It then counts ticks from the first falling edge of `txd` until `shift_empty` rises. A single idle tick between the frames would end the count at one frame length instead of two. A full queue is reached in a similar way. The divisor is held at zero so that no byte drains while sixteen are written.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned SUB_W    = 5;
  localparam int unsigned BIT_TICK = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (divisor == '0) begin
        cnt <= '0;
      end else if (ref_en) begin
        if (cnt >= divisor - DIV_W'(1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fifo_en,
  input  logic         flush,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  input  logic         rd_pop,
  output logic [W-1:0] rd_data,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count, cap;
  logic          push, pop;

  assign cap      = fifo_en ? CW'(DEPTH) : CW'(1);
  assign wr_ready = (count < cap) && !flush;
  assign push     = wr_valid && wr_ready;
  assign pop      = rd_pop && !flush && (count != '0);
  assign empty    = (count == '0);
  assign rd_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              have_data,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              stop_long,
  output logic              pop,
  output logic              ser,
  output logic              idle
);
  tx_state_e         state;
  logic [SUB_W-1:0]  sub, stop_last;
  logic [DATA_W-1:0] shreg, mask;
  logic [2:0]        bit_idx, last_idx;
  logic              parbit, bit_end, stop_end;

  assign mask      = 8'hFF >> (2'd3 - char_len);
  assign last_idx  = 3'd4 + {1'b0, char_len};
  assign stop_last = !stop_long ? SUB_W'(BIT_TICK - 1)
                   : (char_len == 2'd0) ? SUB_W'(BIT_TICK + BIT_TICK/2 - 1)
                   : SUB_W'(2*BIT_TICK - 1);
  assign bit_end   = (sub == SUB_W'(BIT_TICK - 1));
  assign stop_end  = (state == ST_STOP) && (sub == stop_last);
  assign pop       = tick && have_data && ((state == ST_IDLE) || stop_end);
  assign idle      = (state == ST_IDLE);

  always_comb begin
    case (state)
      ST_START: ser = 1'b0;
      ST_DATA:  ser = shreg[0];
      ST_PAR:   ser = parbit;
      default:  ser = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sub     <= '0;
      shreg   <= '0;
      bit_idx <= '0;
      parbit  <= 1'b0;
    end else if (tick) begin
      if (pop) begin
        state   <= ST_START;
        sub     <= '0;
        shreg   <= din & mask;
        parbit  <= (^(din & mask)) ^ ~par_even;
        bit_idx <= '0;
      end else begin
        case (state)
          ST_START: begin
            sub <= bit_end ? '0 : sub + SUB_W'(1);
            if (bit_end) state <= ST_DATA;
          end
          ST_DATA: begin
            sub <= bit_end ? '0 : sub + SUB_W'(1);
            if (bit_end) begin
              shreg <= shreg >> 1;
              if (bit_idx == last_idx) state <= par_en ? ST_PAR : ST_STOP;
              else bit_idx <= bit_idx + 3'd1;
            end
          end
          ST_PAR: begin
            sub <= bit_end ? '0 : sub + SUB_W'(1);
            if (bit_end) state <= ST_STOP;
          end
          ST_STOP: begin
            if (stop_end) begin
              state <= ST_IDLE;
              sub   <= '0;
            end else begin
              sub <= sub + SUB_W'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              fifo_en,
  input  logic [1:0]        char_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              stop_long,
  input  logic              brk,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              clk16_n,
  output logic              hold_empty,
  output logic              shift_empty
);
  logic              tick, flush, fifo_en_q, pop, ser, empty;
  logic [DATA_W-1:0] head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fifo_en_q <= 1'b0;
    else        fifo_en_q <= fifo_en;
  end
  assign flush = fifo_en ^ fifo_en_q;

  uart_tx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .divisor(divisor), .tick(tick)
  );

  uart_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_pop(pop), .rd_data(head), .empty(empty)
  );

  uart_tx_shifter shift_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .have_data(!empty && !flush),
    .din(head), .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .stop_long(stop_long), .pop(pop), .ser(ser), .idle(shift_empty)
  );

  assign txd        = ser && !brk;
  assign clk16_n    = !tick;
  assign hold_empty = empty;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ref_en,
  input logic [15:0] divisor,
  input logic        fifo_en,
  input logic        brk,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        txd,
  input logic        clk16_n,
  input logic        hold_empty,
  input logic        shift_empty
);
  // R10
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  // R5
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(divisor == 16'd0) |-> clk16_n);

  // R5
  tick_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk16_n |-> $past(ref_en));

  // R6
  single_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !hold_empty) |-> !wr_ready);

  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_empty && !brk) |-> txd);

  // R8
  stay_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_empty && !(wr_valid && wr_ready)) |=> hold_empty);
endmodule

bind uart_frame_tx uart_frame_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .divisor(divisor),
  .fifo_en(fifo_en), .brk(brk), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .txd(txd), .clk16_n(clk16_n), .hold_empty(hold_empty),
  .shift_empty(shift_empty)
);

// File: tb/uart_frame_tx_tb_top.sv
`timescale 1ns/1ps
module uart_frame_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b1;
  logic [15:0] divisor = 16'd0;
  logic        fifo_en = 1'b0;
  logic [1:0]  char_len = 2'd3;
  logic        par_en = 1'b0, par_even = 1'b0, stop_long = 1'b0, brk = 1'b0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        wr_ready, txd, clk16_n, hold_empty, shift_empty;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  uart_frame_tx dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .divisor(divisor),
    .fifo_en(fifo_en), .char_len(char_len), .par_en(par_en),
    .par_even(par_even), .stop_long(stop_long), .brk(brk),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .txd(txd), .clk16_n(clk16_n), .hold_empty(hold_empty),
    .shift_empty(shift_empty)
  );

  // {data[22:15], len[14:13], par_en[12], par_even[11], stop_long[10],
  //  expected parity[9], expected ticks to shifter empty[8:0]}
  localparam int NV = 7;
  localparam logic [22:0] VEC [NV] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 9'd160},
    {8'h3C, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 9'd160},
    {8'h13, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 9'd136},
    {8'hFF, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 9'd160},
    {8'h5A, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 9'd176},
    {8'h81, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd112},
    {8'h0F, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 9'd192}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Observes one frame (plus any frame that follows without a gap).
  task automatic run_frame(input logic [7:0] d, input int nbits, input bit pe,
                           input bit pbit, input int exp_ticks, input string tag);
    int guard = 0;
    int ticks = 0;
    int body = 16 * (1 + nbits + (pe ? 1 : 0));
    while (txd && guard < 4000) begin @(negedge clk); guard++; end
    check(!txd, {tag, " start seen"}, txd, 0);
    guard = 0;
    while (!shift_empty && guard < 4000) begin
      @(negedge clk);
      guard++;
      if (!clk16_n) begin
        ticks++;
        if (ticks % 16 == 8 && ticks < body + 16) begin
          int b = ticks / 16;
          bit e;
          if (b == 0) e = 1'b0;
          else if (b <= nbits) e = d[b-1];
          else if (pe && b == nbits + 1) e = pbit;
          else e = 1'b1;
          check(txd == e, {tag, " bit"}, txd, e);
        end
      end
    end
    check(ticks == exp_ticks, {tag, " ticks"}, ticks, exp_ticks);
  endtask

  initial begin
    #(150000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(clk16_n == 1'b1, "R1 clk16_n", clk16_n, 1);
    check(hold_empty == 1'b1, "R1 hold_empty", hold_empty, 1);
    check(shift_empty == 1'b1, "R1 shift_empty", shift_empty, 1);
    check(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);

    // R5 divisor zero: byte waits, no tick, line idle
    put_byte(8'h55);
    check(!wr_ready, "R6 single register full", wr_ready, 0);
    check(!hold_empty, "R8 byte waiting", hold_empty, 0);
    begin
      bit saw_tick = 0, saw_low = 0;
      repeat (40) begin
        @(negedge clk);
        if (!clk16_n) saw_tick = 1;
        if (!txd) saw_low = 1;
      end
      check(!saw_tick, "R5 no tick at divisor 0", saw_tick, 0);
      check(!saw_low, "R5 nothing sent at divisor 0", saw_low, 0);
    end

    // R7 mode change discards
    @(negedge clk); fifo_en = 1'b1;
    @(negedge clk); @(negedge clk);
    check(hold_empty, "R7 flush on mode change", hold_empty, 1);

    // R6 queue depth 16
    for (int i = 0; i < 16; i++) put_byte(8'(i));
    check(!wr_ready, "R6 queue full after 16", wr_ready, 0);
    @(negedge clk); fifo_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check(hold_empty, "R7 queue discarded", hold_empty, 1);
    check(wr_ready, "R6 ready after discard", wr_ready, 1);
    @(negedge clk); fifo_en = 1'b1;
    @(negedge clk); @(negedge clk);

    // R5 tick spacing with divisor 3
    divisor = 16'd3;
    begin
      int t0 = -1, t1 = -1, cyc = 0;
      while (t1 < 0 && cyc < 100) begin
        @(negedge clk); cyc++;
        if (!clk16_n) begin
          if (t0 < 0) t0 = cyc; else t1 = cyc;
        end
      end
      check(t1 - t0 == 3, "R5 tick period", t1 - t0, 3);
    end
    divisor = 16'd2;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R9 vector table
    for (int v = 0; v < NV; v++) begin
      char_len  = VEC[v][14:13];
      par_en    = VEC[v][12];
      par_even  = VEC[v][11];
      stop_long = VEC[v][10];
      put_byte(VEC[v][22:15]);
      run_frame(VEC[v][22:15], 5 + int'(VEC[v][14:13]), VEC[v][12], VEC[v][9],
                int'(VEC[v][8:0]), "R2 R3 R4 frame");
      check(hold_empty, "R8 drained", hold_empty, 1);
    end

    // R9 back-to-back frames without an idle tick
    char_len = 2'd3; par_en = 1'b0; stop_long = 1'b0;
    put_byte(8'hA5);
    put_byte(8'hA5);
    run_frame(8'hA5, 8, 1'b0, 1'b0, 320, "R9 back-to-back");

    // R10 break when idle and mid-frame
    @(negedge clk); brk = 1'b1;
    @(negedge clk);
    check(!txd, "R10 break idle", txd, 0);
    brk = 1'b0;
    @(negedge clk);
    check(txd, "R10 break released", txd, 1);
    put_byte(8'hFF);
    repeat (60) @(negedge clk);
    brk = 1'b1;
    @(negedge clk);
    check(!txd, "R10 break mid-frame", txd, 0);
    brk = 1'b0;
    begin
      int g = 0;
      while (!shift_empty && g < 2000) begin @(negedge clk); g++; end
      check(shift_empty, "R10 frame completes", shift_empty, 1);
      check(txd, "R10 line idle after frame", txd, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule